// File: doc/BRIEF.md
# Per-Core Interrupt Router with IRQ/FIQ Steering

This block collects the interrupt sources of a four-core cluster and produces one normal interrupt (IRQ) and one fast interrupt (FIQ) per core. Each core has four timer lines and four mailbox lines of its own. The mailbox lines are the "nonzero" levels from a separate mailbox block. The cluster also has one shared GPU interrupt, which comes in as a line for the IRQ path and a line for the FIQ path, and one performance-monitor (PMU) line per core.

A small register port sets which sources reach which output. For each timer and mailbox source there is an IRQ enable and an FIQ enable. When the FIQ enable is set, the source goes to the FIQ side only. The GPU lines are steered to one chosen core for each path. The PMU enables are changed through a write-to-set address and a write-to-clear address, so software can change one core's bit without a read-modify-write.

The sources are gated through the enables and assembled into per-core pending words. These pending words are readable at all times. Each core's output is raised whenever its pending word is nonzero. The register port has no back-pressure: a write is taken on every clock edge where `bus_we` is high, and read data is a combinational function of `bus_addr`.

Top module: `irq_router`

## Requirements
- R1: After reset, all timer and mailbox controls, the GPU steering field and the PMU enable mask read as 0. With every source low, all `core_irq` and `core_fiq` outputs are 0.
- R2: The timer control for core c is at byte address 0x40+4c. Bits [3:0] are the IRQ enables of timers 0..3. When timer t of core c is high, its IRQ enable is set and its FIQ enable is clear, bit t of core c's IRQ pending word is 1.
- R3: Bits [7:4] of a timer or mailbox control are FIQ enables. A set FIQ enable places the source in the FIQ pending word and removes it from the IRQ pending word, whatever the IRQ enable holds.
- R4: The mailbox control for core c is at 0x50+4c, with the same enable layout as the timer control. Mailbox m appears at pending bit 4+m.
- R5: The GPU steering register is at 0x0C. Bits [1:0] name the core whose IRQ pending bit 8 follows the GPU IRQ line. Bits [3:2] name the core whose FIQ pending bit 8 follows the GPU FIQ line. All other cores see 0 in bit 8.
- R6: Writing to 0x10 sets the PMU enable bits where the write data has a 1. Writing to 0x14 clears them where the write data has a 1. Zero data bits leave the mask alone. Reading either address returns the 4-bit mask. The change takes effect at the write's clock edge.
- R7: Bit 9 of core c's IRQ pending word is the PMU line of core c ANDed with PMU enable bit c. Bit 9 of every FIQ pending word is 0.
- R8: `core_irq[c]` is 1 exactly when core c's IRQ pending word is nonzero. `core_fiq[c]` is 1 exactly when its FIQ pending word is nonzero.
- R9: The IRQ pending word of core c reads at 0x60+4c and the FIQ pending word at 0x70+4c. These addresses are read-only: writes to them change no register. Unmapped addresses read as 0.
- R10: Control registers read back only their defined bits (8 bits for timer and mailbox controls, 4 bits for GPU steering). All higher read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe, taken at the rising edge |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| tmr_lines | input | 16 | Timer levels, four per core, core c at [4c+3:4c] |
| mbx_lines | input | 16 | Mailbox nonzero levels, four per core, core c at [4c+3:4c] |
| gpu_irq_line | input | 1 | Shared GPU interrupt, IRQ path |
| gpu_fiq_line | input | 1 | Shared GPU interrupt, FIQ path |
| pmu_lines | input | 4 | Per-core performance monitor levels |
| core_irq | output | 4 | Per-core IRQ output |
| core_fiq | output | 4 | Per-core FIQ output |

## Verification
A register write and a source change can meet in the same cycle. For example, a core's PMU line is already high when its enable is written. The bench holds the line high, issues the set write, and samples `core_irq` at the falling edge before the write's capture edge, expecting 0, and again after that edge, expecting 1. The clear write is checked the same way in reverse. Steering and override changes are judged the same way: every pending word and both output vectors are read back and compared with a bench-side model after each write.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int SRC_PER_GRP = 4;
  localparam int CTL_W       = 2 * SRC_PER_GRP;
  localparam int PEND_W      = 2 * SRC_PER_GRP + 2;
  localparam int BIT_TMR     = 0;
  localparam int BIT_MBX     = SRC_PER_GRP;
  localparam int BIT_GPU     = 2 * SRC_PER_GRP;
  localparam int BIT_PMU     = BIT_GPU + 1;

  // address group held in bus_addr[7:4]
  localparam logic [3:0] GRP_MISC = 4'h0;
  localparam logic [3:0] GRP_PMU  = 4'h1;
  localparam logic [3:0] GRP_TMR  = 4'h4;
  localparam logic [3:0] GRP_MBX  = 4'h5;
  localparam logic [3:0] GRP_IRQP = 4'h6;
  localparam logic [3:0] GRP_FIQP = 4'h7;

  localparam logic [1:0] IDX_ROUTE   = 2'd3;
  localparam logic [1:0] IDX_PMU_SET = 2'd0;
  localparam logic [1:0] IDX_PMU_CLR = 2'd1;

  // sources kept on the IRQ side: IRQ-enabled and not claimed by FIQ
  function automatic logic [SRC_PER_GRP-1:0] irq_side(
    input logic [SRC_PER_GRP-1:0] src,
    input logic [CTL_W-1:0]       ctl
  );
    return src & ctl[SRC_PER_GRP-1:0] & ~ctl[CTL_W-1:SRC_PER_GRP];
  endfunction

  function automatic logic [SRC_PER_GRP-1:0] fiq_side(
    input logic [SRC_PER_GRP-1:0] src,
    input logic [CTL_W-1:0]       ctl
  );
    return src & ctl[CTL_W-1:SRC_PER_GRP];
  endfunction
endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
  import irq_router_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int AW    = 8,
  parameter int DW    = 32,
  localparam int CW   = $clog2(NCORE)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_we,
  input  logic [AW-1:0]               bus_addr,
  input  logic [DW-1:0]               bus_wdata,
  output logic [NCORE-1:0][CTL_W-1:0] tmr_ctl,
  output logic [NCORE-1:0][CTL_W-1:0] mbx_ctl,
  output logic [2*CW-1:0]             gpu_route,
  output logic [NCORE-1:0]            pmu_mask
);
  logic [3:0] grp;
  logic [1:0] idx;
  logic       unused_wbits;

  assign grp = bus_addr[7:4];
  assign idx = bus_addr[3:2];
  assign unused_wbits = ^{bus_addr[1:0], bus_wdata[DW-1:CTL_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpu_route <= '0;
      pmu_mask  <= '0;
    end else if (bus_we) begin
      if (grp == GRP_MISC && idx == IDX_ROUTE)
        gpu_route <= bus_wdata[2*CW-1:0];
      if (grp == GRP_PMU && idx == IDX_PMU_SET)
        pmu_mask <= pmu_mask | bus_wdata[NCORE-1:0];
      if (grp == GRP_PMU && idx == IDX_PMU_CLR)
        pmu_mask <= pmu_mask & ~bus_wdata[NCORE-1:0];
    end
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_core_ctl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tmr_ctl[c] <= '0;
        mbx_ctl[c] <= '0;
      end else if (bus_we && idx == 2'(c)) begin
        if (grp == GRP_TMR) tmr_ctl[c] <= bus_wdata[CTL_W-1:0];
        if (grp == GRP_MBX) mbx_ctl[c] <= bus_wdata[CTL_W-1:0];
      end
    end
  end
endmodule

// File: rtl/irq_core_gate.sv
module irq_core_gate
  import irq_router_pkg::*;
(
  input  logic [SRC_PER_GRP-1:0] tmr_src,
  input  logic [SRC_PER_GRP-1:0] mbx_src,
  input  logic [CTL_W-1:0]       tmr_ctl,
  input  logic [CTL_W-1:0]       mbx_ctl,
  input  logic                   gpu_irq_hit,
  input  logic                   gpu_fiq_hit,
  input  logic                   pmu_hit,
  output logic [PEND_W-1:0]      irq_pend,
  output logic [PEND_W-1:0]      fiq_pend,
  output logic                   irq_out,
  output logic                   fiq_out
);
  always_comb begin
    irq_pend = '0;
    fiq_pend = '0;
    irq_pend[BIT_TMR +: SRC_PER_GRP] = irq_side(tmr_src, tmr_ctl);
    irq_pend[BIT_MBX +: SRC_PER_GRP] = irq_side(mbx_src, mbx_ctl);
    irq_pend[BIT_GPU]                = gpu_irq_hit;
    irq_pend[BIT_PMU]                = pmu_hit;
    fiq_pend[BIT_TMR +: SRC_PER_GRP] = fiq_side(tmr_src, tmr_ctl);
    fiq_pend[BIT_MBX +: SRC_PER_GRP] = fiq_side(mbx_src, mbx_ctl);
    fiq_pend[BIT_GPU]                = gpu_fiq_hit;
  end

  assign irq_out = |irq_pend;
  assign fiq_out = |fiq_pend;
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int AW    = 8,
  parameter int DW    = 32,
  localparam int CW   = $clog2(NCORE),
  localparam int NSRC = NCORE * SRC_PER_GRP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NSRC-1:0]  tmr_lines,
  input  logic [NSRC-1:0]  mbx_lines,
  input  logic             gpu_irq_line,
  input  logic             gpu_fiq_line,
  input  logic [NCORE-1:0] pmu_lines,
  output logic [NCORE-1:0] core_irq,
  output logic [NCORE-1:0] core_fiq
);
  logic [NCORE-1:0][CTL_W-1:0]  tmr_ctl;
  logic [NCORE-1:0][CTL_W-1:0]  mbx_ctl;
  logic [2*CW-1:0]              gpu_route;
  logic [NCORE-1:0]             pmu_mask;
  logic [NCORE-1:0][PEND_W-1:0] irq_pend;
  logic [NCORE-1:0][PEND_W-1:0] fiq_pend;
  logic [3:0]                   rd_grp;
  logic [1:0]                   rd_idx;

  irq_router_regs #(.NCORE(NCORE), .AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .tmr_ctl   (tmr_ctl),
    .mbx_ctl   (mbx_ctl),
    .gpu_route (gpu_route),
    .pmu_mask  (pmu_mask)
  );

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    irq_core_gate u_gate (
      .tmr_src     (tmr_lines[c*SRC_PER_GRP +: SRC_PER_GRP]),
      .mbx_src     (mbx_lines[c*SRC_PER_GRP +: SRC_PER_GRP]),
      .tmr_ctl     (tmr_ctl[c]),
      .mbx_ctl     (mbx_ctl[c]),
      .gpu_irq_hit (gpu_irq_line && gpu_route[CW-1:0] == CW'(c)),
      .gpu_fiq_hit (gpu_fiq_line && gpu_route[2*CW-1:CW] == CW'(c)),
      .pmu_hit     (pmu_lines[c] && pmu_mask[c]),
      .irq_pend    (irq_pend[c]),
      .fiq_pend    (fiq_pend[c]),
      .irq_out     (core_irq[c]),
      .fiq_out     (core_fiq[c])
    );
  end

  assign rd_grp = bus_addr[7:4];
  assign rd_idx = bus_addr[3:2];

  always_comb begin
    bus_rdata = '0;
    if (rd_grp == GRP_MISC && rd_idx == IDX_ROUTE)
      bus_rdata[2*CW-1:0] = gpu_route;
    if (rd_grp == GRP_PMU && (rd_idx == IDX_PMU_SET || rd_idx == IDX_PMU_CLR))
      bus_rdata[NCORE-1:0] = pmu_mask;
    for (int c = 0; c < NCORE; c++) begin
      if (rd_idx == 2'(c)) begin
        if (rd_grp == GRP_TMR)  bus_rdata[CTL_W-1:0]  = tmr_ctl[c];
        if (rd_grp == GRP_MBX)  bus_rdata[CTL_W-1:0]  = mbx_ctl[c];
        if (rd_grp == GRP_IRQP) bus_rdata[PEND_W-1:0] = irq_pend[c];
        if (rd_grp == GRP_FIQP) bus_rdata[PEND_W-1:0] = fiq_pend[c];
      end
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int AW    = 8,
  parameter int DW    = 32,
  localparam int CW   = $clog2(NCORE)
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         bus_we,
  input logic [AW-1:0]                bus_addr,
  input logic [DW-1:0]                bus_wdata,
  input logic [NCORE*CTL_W-1:0]       tmr_ctl,
  input logic [NCORE*CTL_W-1:0]       mbx_ctl,
  input logic [2*CW-1:0]              gpu_route,
  input logic [NCORE-1:0]             pmu_mask,
  input logic [NCORE*PEND_W-1:0]      irq_pend,
  input logic [NCORE*PEND_W-1:0]      fiq_pend
);
  logic [NCORE-1:0] gpu_irq_bits;
  logic [NCORE-1:0] gpu_fiq_bits;

  always_comb begin
    for (int c = 0; c < NCORE; c++) begin
      gpu_irq_bits[c] = irq_pend[c*PEND_W + BIT_GPU];
      gpu_fiq_bits[c] = fiq_pend[c*PEND_W + BIT_GPU];
    end
  end

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (tmr_ctl == '0 && mbx_ctl == '0 && gpu_route == '0 && pmu_mask == '0)); // R1

  AST_PMU_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[7:2] == 6'h04) |=> pmu_mask == ($past(pmu_mask) | $past(bus_wdata[NCORE-1:0]))); // R6

  AST_PMU_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[7:2] == 6'h05) |=> pmu_mask == ($past(pmu_mask) & ~$past(bus_wdata[NCORE-1:0]))); // R6

  AST_PEND_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[7:5] == 3'b011) |=>
      ($stable(tmr_ctl) && $stable(mbx_ctl) && $stable(gpu_route) && $stable(pmu_mask))); // R9

  AST_GPU_SINGLE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gpu_irq_bits)); // R5

  AST_GPU_SINGLE_FIQ: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gpu_fiq_bits)); // R5

  for (genvar c = 0; c < NCORE; c++) begin : g_core_chk
    AST_NO_DOUBLE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend[c*PEND_W +: BIT_GPU] & fiq_pend[c*PEND_W +: BIT_GPU]) == '0); // R3
    AST_PMU_NOT_FIQ: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_pend[c*PEND_W + BIT_PMU] == 1'b0); // R7
  end
endmodule

bind irq_router irq_router_chk #(.NCORE(NCORE), .AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .tmr_ctl   (tmr_ctl),
  .mbx_ctl   (mbx_ctl),
  .gpu_route (gpu_route),
  .pmu_mask  (pmu_mask),
  .irq_pend  (irq_pend),
  .fiq_pend  (fiq_pend)
);

// File: tb/test_irq_router.sv
`timescale 1ns/100ps
module test_irq_router;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] tmr_lines = '0;
  logic [15:0] mbx_lines = '0;
  logic        gpu_irq_line = 1'b0;
  logic        gpu_fiq_line = 1'b0;
  logic [3:0]  pmu_lines = '0;
  logic [3:0]  core_irq;
  logic [3:0]  core_fiq;

  always #2.5 clk = ~clk;

  irq_router i_irq_router (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_lines(tmr_lines),
    .mbx_lines(mbx_lines), .gpu_irq_line(gpu_irq_line), .gpu_fiq_line(gpu_fiq_line),
    .pmu_lines(pmu_lines), .core_irq(core_irq), .core_fiq(core_fiq)
  );

  // bench-side model of the control state
  logic [7:0] m_tmr [NC];
  logic [7:0] m_mbx [NC];
  logic [3:0] m_route;
  logic [3:0] m_pmu;

  typedef struct {
    logic [31:0] exp;
    int          kind;   // 0: read data, 1: IRQ vector, 2: FIQ vector
    string       req;
  } item_t;
  item_t sb[$];

  int  n_chk = 0;
  int  n_fail = 0;
  logic chk_go = 1'b0;
  logic done = 1'b0;

  function automatic logic [9:0] m_irq(int c);
    logic [3:0] t, m;
    t = tmr_lines[c*4 +: 4];
    m = mbx_lines[c*4 +: 4];
    return {pmu_lines[c] & m_pmu[c],
            gpu_irq_line & (m_route[1:0] == 2'(c)),
            m & m_mbx[c][3:0] & ~m_mbx[c][7:4],
            t & m_tmr[c][3:0] & ~m_tmr[c][7:4]};
  endfunction

  function automatic logic [9:0] m_fiq(int c);
    return {1'b0, gpu_fiq_line & (m_route[3:2] == 2'(c)),
            mbx_lines[c*4 +: 4] & m_mbx[c][7:4],
            tmr_lines[c*4 +: 4] & m_tmr[c][7:4]};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard at the falling edge
  always @(negedge clk) begin
    if (chk_go && sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.kind)
        0:       act = bus_rdata;
        1:       act = {28'b0, core_irq};
        default: act = {28'b0, core_fiq};
      endcase
      chk(act, it.exp, it.req);
    end
  end

  // driver: one scoreboard item per cycle
  task automatic push(input int kind, input logic [7:0] a, input logic [31:0] exp, input string req);
    item_t it;
    @(posedge clk); #1;
    if (kind == 0) bus_addr = a;
    it.exp = exp; it.kind = kind; it.req = req;
    sb.push_back(it);
    chk_go = 1'b1;
    @(posedge clk); #1;
    chk_go = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    push(0, a, exp, req);
  endtask

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    if (a == 8'h0C) m_route = d[3:0];
    if (a == 8'h10) m_pmu = m_pmu | d[3:0];
    if (a == 8'h14) m_pmu = m_pmu & ~d[3:0];
    if (a[7:4] == 4'h4) m_tmr[a[3:2]] = d[7:0];
    if (a[7:4] == 4'h5) m_mbx[a[3:2]] = d[7:0];
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic check_all(input string req);
    logic [3:0] ei, ef;
    for (int c = 0; c < NC; c++) begin
      rd(8'h60 + 8'(4*c), {22'b0, m_irq(c)}, req);
      rd(8'h70 + 8'(4*c), {22'b0, m_fiq(c)}, req);
    end
    for (int c = 0; c < NC; c++) begin
      ei[c] = |m_irq(c);
      ef[c] = |m_fiq(c);
    end
    push(1, 8'h00, {28'b0, ei}, "R8");
    push(2, 8'h00, {28'b0, ef}, "R8");
  endtask

  initial begin
    for (int c = 0; c < NC; c++) begin m_tmr[c] = '0; m_mbx[c] = '0; end
    m_route = '0; m_pmu = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    rd(8'h40, 32'h0, "R1");
    rd(8'h58, 32'h0, "R1");
    rd(8'h0C, 32'h0, "R1");
    rd(8'h10, 32'h0, "R1");
    check_all("R1");

    // R2: timer IRQ enables on core 1
    tmr_lines = 16'h0050;
    wr(8'h44, 32'h05);
    check_all("R2");

    // R3: FIQ enable on timer 2 overrides its IRQ enable
    wr(8'h44, 32'h45);
    check_all("R3");

    // R4: mailbox 0 on IRQ, mailbox 3 on FIQ, core 2
    mbx_lines = 16'h0900;
    wr(8'h58, 32'h81);
    check_all("R4");

    // R5: GPU steering, IRQ to core 2 and FIQ to core 3, then IRQ to core 1 and FIQ to core 0
    gpu_irq_line = 1'b1;
    gpu_fiq_line = 1'b1;
    wr(8'h0C, 32'h0E);
    check_all("R5");
    wr(8'h0C, 32'h01);
    check_all("R5");

    // R6 / R7: PMU set and clear, readback from either address
    wr(8'h10, 32'h0A);
    rd(8'h14, 32'h0A, "R6");
    wr(8'h14, 32'h02);
    rd(8'h10, 32'h08, "R6");
    pmu_lines = 4'hF;
    check_all("R7");

    // R6 with a live source: enable change lands exactly at its write edge
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h1;
    @(negedge clk);
    chk({31'b0, core_irq[0]}, 32'h0, "R6");
    @(posedge clk); #1;
    bus_we = 1'b0; model_write(8'h10, 32'h1);
    @(negedge clk);
    chk({31'b0, core_irq[0]}, 32'h1, "R6");
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h1;
    @(negedge clk);
    chk({31'b0, core_irq[0]}, 32'h1, "R6");
    @(posedge clk); #1;
    bus_we = 1'b0; model_write(8'h14, 32'h1);
    @(negedge clk);
    chk({31'b0, core_irq[0]}, 32'h0, "R6");

    // R9: writes to pending addresses change nothing; unmapped reads 0
    wr(8'h64, 32'hFFFF_FFFF);
    wr(8'h70, 32'hFFFF_FFFF);
    rd(8'h44, 32'h45, "R9");
    rd(8'h10, 32'h08, "R9");
    rd(8'h0C, 32'h01, "R9");
    check_all("R9");
    rd(8'h20, 32'h0, "R9");
    rd(8'h08, 32'h0, "R9");

    // R10: only defined bits read back
    wr(8'h4C, 32'hFFFF_FF3C);
    rd(8'h4C, 32'h3C, "R10");
    wr(8'h0C, 32'hFFFF_FFF5);
    rd(8'h0C, 32'h05, "R10");
    tmr_lines = 16'hF0F0;
    check_all("R10");

    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule